// File: doc/BRIEF.md
# Double-Buffered Four-Channel DMA Controller

This block is a multi-channel DMA engine in which every channel keeps two copies of its transfer parameters. Software writes a programmed copy (source address, destination address, byte count) through a plain control port. The engine works only from a hidden active copy. Enabling an idle channel loads the active copy from the programmed one and starts the channel. Enabling a channel that is already running only queues the programmed copy. That copy is then loaded in the same visit that finds the active count drained, so a second job follows the first with no idle gap.

The engine serves one channel per tick, in ascending rotation. A visit to a running channel with bytes left issues one burst command of at most `BURST` bytes on a valid/ready output stream. The command carries source, destination, length and channel number. The valid signal and the payload hold until ready is seen. While a command waits for acceptance the rotation stops, so back-pressure stalls the whole engine. A drained channel raises a completion event. For test, a channel can skip the bit for one completion through a suppression count, and can be made to fail after a chosen number of visits through a fault countdown. Completion and error bits stay set until software clears them with a write-one-to-clear mask.

Top module: `dbdma_ctrl`

## Requirements
- R1: An enable on a channel whose run flag is clear copies the programmed source, destination and count into the active set and sets the run flag. A program write in the same cycle is seen by that copy.
- R2: An enable on a channel whose run flag is set only sets that channel's pending flag and leaves its active set unchanged. The pending flag is never set while the run flag is clear.
- R3: A visit to a running channel with a non-zero active count issues one burst of min(count, `BURST`) bytes, where `BURST` defaults to 2048, from the current active addresses. Both active addresses then advance by that length and the count drops by it.
- R4: A visit to a running channel whose active count is zero while the pending flag is set loads the programmed set into the active set, clears the pending flag, keeps the run flag set and raises a completion event.
- R5: A visit to a running channel whose active count is zero while no set is pending clears the run flag and raises a completion event.
- R6: A completion event on channel n sets bit n of `cpl_vec`, unless the channel's suppression count is 1. In that case the count returns to 0 and no bit is set.
- R7: A stop command clears both the run flag and the pending flag of the addressed channel. Stop wins over an enable in the same cycle.
- R8: A suppression request is accepted only when the addressed channel is idle and the requested value is exactly 1. Acceptance arms the count and clears `sup_nack`. Any other request is refused and sets `sup_nack`, which holds its value until the next request.
- R9: The fault countdown of a channel, when non-zero, is decremented on each visit while the channel runs. The visit on which it reaches zero issues no burst, clears the run and pending flags and sets bit n of `err_vec`.
- R10: A 1 in bit n of `cpl_clr` or `err_clr` clears bit n of the matching vector. A set raised in the same cycle wins over the clear.
- R11: A tick occurs on every cycle except when `mv_valid` is 1 and `mv_ready` is 0. Each tick visits one channel, in the order 0, 1, 2, 3, 0, and so on. A visit to the channel that software addresses with any strobe in that cycle is skipped, but the rotation still advances.
- R12: After reset all flags and vectors are 0 and `mv_valid` is 0. While `mv_valid` is 1 and `mv_ready` is 0, `mv_valid`, `mv_src`, `mv_dst`, `mv_len` and `mv_chan` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_chan | input | 2 | Channel addressed by every software strobe |
| sw_prog_we | input | 1 | Write the programmed set |
| sw_src | input | 32 | Programmed source address |
| sw_dst | input | 32 | Programmed destination address |
| sw_cnt | input | 13 | Programmed byte count |
| sw_enable | input | 1 | Enable command |
| sw_stop | input | 1 | Stop command |
| sw_fault_we | input | 1 | Load the fault countdown |
| sw_fault_val | input | 4 | Fault countdown value (0 disables) |
| sw_sup_req | input | 1 | Completion-suppression request |
| sw_sup_val | input | 4 | Requested suppression count |
| cpl_clr | input | 4 | Write-one-to-clear mask for completion bits |
| err_clr | input | 4 | Write-one-to-clear mask for error bits |
| ch_run | output | 4 | Run flag per channel |
| ch_pend | output | 4 | Pending flag per channel |
| cpl_vec | output | 4 | Completion bits |
| err_vec | output | 4 | Error bits |
| sup_nack | output | 1 | Last suppression request was refused |
| mv_valid | output | 1 | Burst command valid |
| mv_ready | input | 1 | Burst command accepted |
| mv_src | output | 32 | Burst source address |
| mv_dst | output | 32 | Burst destination address |
| mv_len | output | 13 | Burst length in bytes |
| mv_chan | output | 2 | Channel issuing the burst |

## Verification
The assertions check on every cycle the properties that hold locally in time. The pending flag is never set without the run flag. Enable and stop commands have their effect one cycle later. A fault visit always leaves the channel stopped. Burst commands stay stable under back-pressure and never exceed the burst limit. At most one completion is raised per tick, and the rotation pointer advances only on ticks. Only the bench's scenarios can show the longer sequences: a queued job swapped in after several bursts with the right total byte count, one suppressed completion followed by a reported one, a fault that triggers on the second visit, and the interleaving of four channels under an irregular ready pattern, all checked against a behavioural model every clock.

// File: rtl/dbdma_pkg.sv
package dbdma_pkg;
  // What a single scheduler visit does to the visited channel
  typedef enum logic [2:0] {
    VIS_NONE  = 3'd0,
    VIS_MOVE  = 3'd1,
    VIS_SWAP  = 3'd2,
    VIS_DONE  = 3'd3,
    VIS_FAULT = 3'd4
  } vis_e;
endpackage

// File: rtl/dbdma_sched.sv
module dbdma_sched #(
  parameter int NCH = 4,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  output logic [CHW-1:0] cur
);
  logic [CHW-1:0] cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= '0;
    else if (tick) cur_q <= (cur_q == CHW'(NCH - 1)) ? '0 : cur_q + CHW'(1);
  end

  assign cur = cur_q;

  a_r11_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cur_q));
  a_r11_move_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cur_q != $past(cur_q));
endmodule

// File: rtl/dbdma_chan.sv
module dbdma_chan
  import dbdma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CW    = 13,
  parameter int FW    = 4,
  parameter int BURST = 2048
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          visit,
  input  logic          prog_we,
  input  logic [AW-1:0] prog_src,
  input  logic [AW-1:0] prog_dst,
  input  logic [CW-1:0] prog_cnt,
  input  logic          en_cmd,
  input  logic          stop_cmd,
  input  logic          fault_we,
  input  logic [FW-1:0] fault_val,
  input  logic          sup_set,
  output logic          run,
  output logic          pend,
  output logic [AW-1:0] act_src,
  output logic [AW-1:0] act_dst,
  output logic [CW-1:0] mv_len,
  output vis_e          outcome,
  output logic          cpl_evt,
  output logic          err_evt
);
  localparam logic [CW-1:0] BLEN = CW'(BURST);

  logic [AW-1:0] p_src_q, p_dst_q, a_src_q, a_dst_q;
  logic [CW-1:0] p_cnt_q, a_cnt_q;
  logic [AW-1:0] p_src_n, p_dst_n;
  logic [CW-1:0] p_cnt_n;
  logic [FW-1:0] fault_q;
  logic          run_q, pend_q, sup_q;

  // programmed set as seen by an enable in this cycle
  assign p_src_n = prog_we ? prog_src : p_src_q;
  assign p_dst_n = prog_we ? prog_dst : p_dst_q;
  assign p_cnt_n = prog_we ? prog_cnt : p_cnt_q;

  assign mv_len = (a_cnt_q > BLEN) ? BLEN : a_cnt_q;

  always_comb begin
    outcome = VIS_NONE;
    if (visit && run_q) begin
      if (fault_q == FW'(1))  outcome = VIS_FAULT;
      else if (a_cnt_q == '0) outcome = pend_q ? VIS_SWAP : VIS_DONE;
      else                    outcome = VIS_MOVE;
    end
  end

  assign cpl_evt = (outcome == VIS_SWAP || outcome == VIS_DONE) && !sup_q;
  assign err_evt = (outcome == VIS_FAULT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_src_q <= '0; p_dst_q <= '0; p_cnt_q <= '0;
      a_src_q <= '0; a_dst_q <= '0; a_cnt_q <= '0;
      fault_q <= '0; run_q <= 1'b0; pend_q <= 1'b0; sup_q <= 1'b0;
    end else begin
      // scheduler visit (never coincides with a command on this channel)
      if (visit && run_q && fault_q != '0) fault_q <= fault_q - FW'(1);
      unique case (outcome)
        VIS_MOVE: begin
          a_cnt_q <= a_cnt_q - mv_len;
          a_src_q <= a_src_q + AW'(mv_len);
          a_dst_q <= a_dst_q + AW'(mv_len);
        end
        VIS_SWAP: begin
          a_src_q <= p_src_q; a_dst_q <= p_dst_q; a_cnt_q <= p_cnt_q;
          pend_q  <= 1'b0;
        end
        VIS_DONE:  run_q <= 1'b0;
        VIS_FAULT: begin run_q <= 1'b0; pend_q <= 1'b0; end
        default: ;
      endcase
      if ((outcome == VIS_SWAP || outcome == VIS_DONE) && sup_q) sup_q <= 1'b0;

      // software commands
      if (prog_we) begin
        p_src_q <= prog_src; p_dst_q <= prog_dst; p_cnt_q <= prog_cnt;
      end
      if (fault_we) fault_q <= fault_val;
      if (sup_set)  sup_q   <= 1'b1;
      if (stop_cmd) begin
        run_q <= 1'b0; pend_q <= 1'b0;
      end else if (en_cmd) begin
        if (run_q) pend_q <= 1'b1;
        else begin
          a_src_q <= p_src_n; a_dst_q <= p_dst_n; a_cnt_q <= p_cnt_n;
          run_q   <= 1'b1;
        end
      end
    end
  end

  assign run     = run_q;
  assign pend    = pend_q;
  assign act_src = a_src_q;
  assign act_dst = a_dst_q;

  a_r2_pend_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> run_q);
  a_r1_idle_enable: assert property (@(posedge clk) disable iff (!rst_n)
    en_cmd && !stop_cmd && !run_q |=> run_q && a_cnt_q == $past(p_cnt_n) && a_src_q == $past(p_src_n));
  a_r2_busy_enable: assert property (@(posedge clk) disable iff (!rst_n)
    en_cmd && !stop_cmd && run_q |=> pend_q && $stable(a_cnt_q) && $stable(a_src_q) && $stable(a_dst_q));
  a_r7_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stop_cmd |=> !run_q && !pend_q);
  a_r9_fault_stops: assert property (@(posedge clk) disable iff (!rst_n)
    outcome == VIS_FAULT |=> !run_q && !pend_q);
  a_r4_swap_keeps_run: assert property (@(posedge clk) disable iff (!rst_n)
    outcome == VIS_SWAP |=> run_q && !pend_q);
endmodule

// File: rtl/dbdma_ctrl.sv
module dbdma_ctrl
  import dbdma_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int AW    = 32,
  parameter int CW    = 13,
  parameter int FW    = 4,
  parameter int SW    = 4,
  parameter int BURST = 2048,
  localparam int CHW  = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CHW-1:0] sw_chan,
  input  logic           sw_prog_we,
  input  logic [AW-1:0]  sw_src,
  input  logic [AW-1:0]  sw_dst,
  input  logic [CW-1:0]  sw_cnt,
  input  logic           sw_enable,
  input  logic           sw_stop,
  input  logic           sw_fault_we,
  input  logic [FW-1:0]  sw_fault_val,
  input  logic           sw_sup_req,
  input  logic [SW-1:0]  sw_sup_val,
  input  logic [NCH-1:0] cpl_clr,
  input  logic [NCH-1:0] err_clr,
  output logic [NCH-1:0] ch_run,
  output logic [NCH-1:0] ch_pend,
  output logic [NCH-1:0] cpl_vec,
  output logic [NCH-1:0] err_vec,
  output logic           sup_nack,
  output logic           mv_valid,
  input  logic           mv_ready,
  output logic [AW-1:0]  mv_src,
  output logic [AW-1:0]  mv_dst,
  output logic [CW-1:0]  mv_len,
  output logic [CHW-1:0] mv_chan
);
  logic           tick, sw_any, sup_ok;
  logic [CHW-1:0] cur;
  logic [NCH-1:0] cpl_set, err_set;
  vis_e           outc  [NCH];
  logic [AW-1:0]  c_src [NCH];
  logic [AW-1:0]  c_dst [NCH];
  logic [CW-1:0]  c_len [NCH];

  logic           mv_valid_q, sup_nack_q;
  logic [AW-1:0]  mv_src_q, mv_dst_q;
  logic [CW-1:0]  mv_len_q;
  logic [CHW-1:0] mv_chan_q;
  logic [NCH-1:0] cpl_q, err_q;

  assign tick   = !mv_valid_q || mv_ready;
  assign sw_any = sw_prog_we | sw_enable | sw_stop | sw_fault_we | sw_sup_req;
  assign sup_ok = !ch_run[sw_chan] && (sw_sup_val == SW'(1));

  dbdma_sched #(.NCH(NCH)) u_sched (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cur(cur)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sel;
    assign sel = (sw_chan == CHW'(i));
    dbdma_chan #(.AW(AW), .CW(CW), .FW(FW), .BURST(BURST)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .visit    (tick && cur == CHW'(i) && !(sw_any && sel)),
      .prog_we  (sw_prog_we && sel),
      .prog_src (sw_src),
      .prog_dst (sw_dst),
      .prog_cnt (sw_cnt),
      .en_cmd   (sw_enable && sel),
      .stop_cmd (sw_stop && sel),
      .fault_we (sw_fault_we && sel),
      .fault_val(sw_fault_val),
      .sup_set  (sw_sup_req && sel && sup_ok),
      .run      (ch_run[i]),
      .pend     (ch_pend[i]),
      .act_src  (c_src[i]),
      .act_dst  (c_dst[i]),
      .mv_len   (c_len[i]),
      .outcome  (outc[i]),
      .cpl_evt  (cpl_set[i]),
      .err_evt  (err_set[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mv_valid_q <= 1'b0;
      mv_src_q   <= '0; mv_dst_q <= '0; mv_len_q <= '0; mv_chan_q <= '0;
      cpl_q      <= '0; err_q <= '0; sup_nack_q <= 1'b0;
    end else begin
      if (tick) begin
        mv_valid_q <= (outc[cur] == VIS_MOVE);
        if (outc[cur] == VIS_MOVE) begin
          mv_src_q  <= c_src[cur];
          mv_dst_q  <= c_dst[cur];
          mv_len_q  <= c_len[cur];
          mv_chan_q <= cur;
        end
      end
      cpl_q <= (cpl_q & ~cpl_clr) | cpl_set;
      err_q <= (err_q & ~err_clr) | err_set;
      if (sw_sup_req) sup_nack_q <= !sup_ok;
    end
  end

  assign mv_valid = mv_valid_q;
  assign mv_src   = mv_src_q;
  assign mv_dst   = mv_dst_q;
  assign mv_len   = mv_len_q;
  assign mv_chan  = mv_chan_q;
  assign cpl_vec  = cpl_q;
  assign err_vec  = err_q;
  assign sup_nack = sup_nack_q;

  a_r12_hold_under_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    mv_valid && !mv_ready |=> mv_valid && $stable(mv_src) && $stable(mv_dst)
                              && $stable(mv_len) && $stable(mv_chan));
  a_r3_len_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    mv_valid |-> mv_len != '0 && mv_len <= CW'(BURST));
  a_r6_one_completion_per_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cpl_set | err_set));
  a_r8_busy_request_refused: assert property (@(posedge clk) disable iff (!rst_n)
    sw_sup_req && ch_run[sw_chan] |=> sup_nack);
  a_r10_clear_without_set: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_clr[0] && !cpl_set[0]) |=> !cpl_vec[0]);
endmodule

// File: tb/tb_dbdma_ctrl.sv
module tb_dbdma_ctrl;
  localparam int BURST = 2048;

  logic        clk = 0, rst_n = 0;
  logic [1:0]  sw_chan = 0;
  logic        sw_prog_we = 0, sw_enable = 0, sw_stop = 0, sw_fault_we = 0, sw_sup_req = 0;
  logic [31:0] sw_src = 0, sw_dst = 0;
  logic [12:0] sw_cnt = 0;
  logic [3:0]  sw_fault_val = 0, sw_sup_val = 0, cpl_clr = 0, err_clr = 0;
  logic [3:0]  ch_run, ch_pend, cpl_vec, err_vec;
  logic        sup_nack, mv_valid, mv_ready = 1;
  logic [31:0] mv_src, mv_dst;
  logic [12:0] mv_len;
  logic [1:0]  mv_chan;

  always #10 clk = ~clk;

  dbdma_ctrl dut (
    .clk(clk), .rst_n(rst_n), .sw_chan(sw_chan), .sw_prog_we(sw_prog_we),
    .sw_src(sw_src), .sw_dst(sw_dst), .sw_cnt(sw_cnt), .sw_enable(sw_enable),
    .sw_stop(sw_stop), .sw_fault_we(sw_fault_we), .sw_fault_val(sw_fault_val),
    .sw_sup_req(sw_sup_req), .sw_sup_val(sw_sup_val), .cpl_clr(cpl_clr),
    .err_clr(err_clr), .ch_run(ch_run), .ch_pend(ch_pend), .cpl_vec(cpl_vec),
    .err_vec(err_vec), .sup_nack(sup_nack), .mv_valid(mv_valid), .mv_ready(mv_ready),
    .mv_src(mv_src), .mv_dst(mv_dst), .mv_len(mv_len), .mv_chan(mv_chan)
  );

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_psrc[4], m_pdst[4], m_asrc[4], m_adst[4];
  int          m_pcnt[4], m_acnt[4], m_fault[4];
  bit          m_run[4], m_pend[4], m_sup[4];
  logic [3:0]  m_cpl, m_err;
  bit          m_nack, m_mvv;
  int          m_cur;
  logic [31:0] m_mvs, m_mvd;
  int          m_mvl, m_mvc;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_psrc[i] = 0; m_pdst[i] = 0; m_asrc[i] = 0; m_adst[i] = 0;
        m_pcnt[i] = 0; m_acnt[i] = 0; m_fault[i] = 0;
        m_run[i] = 0; m_pend[i] = 0; m_sup[i] = 0;
      end
      m_cpl = 0; m_err = 0; m_nack = 0; m_mvv = 0; m_cur = 0;
      m_mvs = 0; m_mvd = 0; m_mvl = 0; m_mvc = 0;
    end else begin
      bit tick, touch, issued;
      logic [3:0] cs, es;
      int v, c;
      tick = !m_mvv || mv_ready;
      touch = sw_prog_we | sw_enable | sw_stop | sw_fault_we | sw_sup_req;
      cs = 0; es = 0; issued = 0;
      if (tick) begin
        v = m_cur;
        if (m_run[v] && !(touch && sw_chan == v)) begin
          bit hit;
          hit = 0;
          if (m_fault[v] > 0) begin m_fault[v]--; hit = (m_fault[v] == 0); end
          if (hit) begin m_run[v] = 0; m_pend[v] = 0; es[v] = 1; end
          else if (m_acnt[v] == 0) begin
            if (m_pend[v]) begin
              m_asrc[v] = m_psrc[v]; m_adst[v] = m_pdst[v]; m_acnt[v] = m_pcnt[v];
              m_pend[v] = 0;
            end else m_run[v] = 0;
            if (m_sup[v]) m_sup[v] = 0; else cs[v] = 1;
          end else begin
            int s;
            s = (m_acnt[v] < BURST) ? m_acnt[v] : BURST;
            m_mvs = m_asrc[v]; m_mvd = m_adst[v]; m_mvl = s; m_mvc = v;
            m_acnt[v] -= s; m_asrc[v] += 32'(s); m_adst[v] += 32'(s);
            issued = 1;
          end
        end
        m_mvv = issued;
        m_cur = (m_cur + 1) % 4;
      end
      m_cpl = (m_cpl & ~cpl_clr) | cs;
      m_err = (m_err & ~err_clr) | es;
      c = sw_chan;
      if (sw_prog_we) begin m_psrc[c] = sw_src; m_pdst[c] = sw_dst; m_pcnt[c] = sw_cnt; end
      if (sw_fault_we) m_fault[c] = sw_fault_val;
      if (sw_sup_req) begin
        if (!m_run[c] && sw_sup_val == 1) begin m_sup[c] = 1; m_nack = 0; end
        else m_nack = 1;
      end
      if (sw_stop) begin m_run[c] = 0; m_pend[c] = 0; end
      else if (sw_enable) begin
        if (m_run[c]) m_pend[c] = 1;
        else begin
          m_asrc[c] = m_psrc[c]; m_adst[c] = m_pdst[c]; m_acnt[c] = m_pcnt[c];
          m_run[c] = 1;
        end
      end
    end
  end

  // per-clock comparison, away from the active edge
  int bytes_ch0 = 0, bursts_ch0 = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [3:0] er, ep;
      for (int i = 0; i < 4; i++) begin er[i] = m_run[i]; ep[i] = m_pend[i]; end
      chk(ch_run == er,  "R1/R5/R9", "ch_run", 64'(ch_run), 64'(er));
      chk(ch_pend == ep, "R2/R4/R7", "ch_pend", 64'(ch_pend), 64'(ep));
      chk(cpl_vec == m_cpl, "R6/R10", "cpl_vec", 64'(cpl_vec), 64'(m_cpl));
      chk(err_vec == m_err, "R9/R10", "err_vec", 64'(err_vec), 64'(m_err));
      chk(sup_nack == m_nack, "R8", "sup_nack", 64'(sup_nack), 64'(m_nack));
      chk(mv_valid == m_mvv, "R12", "mv_valid", 64'(mv_valid), 64'(m_mvv));
      if (mv_valid && m_mvv) begin
        chk(mv_src == m_mvs && mv_dst == m_mvd, "R3", "mv_src", 64'(mv_src), 64'(m_mvs));
        chk(mv_len == 13'(m_mvl), "R3", "mv_len", 64'(mv_len), 64'(m_mvl));
        chk(mv_chan == 2'(m_mvc), "R11", "mv_chan", 64'(mv_chan), 64'(m_mvc));
      end
      if (mv_valid && mv_ready && mv_chan == 0) begin
        bytes_ch0 += int'(mv_len); bursts_ch0++;
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic pulse();
    @(negedge clk);
    sw_prog_we = 0; sw_enable = 0; sw_stop = 0; sw_fault_we = 0; sw_sup_req = 0;
    cpl_clr = 0; err_clr = 0;
  endtask
  task automatic prog(input int ch, input logic [31:0] s, input logic [31:0] d, input int n);
    sw_chan = 2'(ch); sw_src = s; sw_dst = d; sw_cnt = 13'(n); sw_prog_we = 1; pulse();
  endtask
  task automatic enable(input int ch);
    sw_chan = 2'(ch); sw_enable = 1; pulse();
  endtask
  task automatic stop(input int ch);
    sw_chan = 2'(ch); sw_stop = 1; pulse();
  endtask
  task automatic fault(input int ch, input int n);
    sw_chan = 2'(ch); sw_fault_val = 4'(n); sw_fault_we = 1; pulse();
  endtask
  task automatic sup(input int ch, input int n);
    sw_chan = 2'(ch); sw_sup_val = 4'(n); sw_sup_req = 1; pulse();
  endtask
  task automatic clr(input logic [3:0] cm, input logic [3:0] em);
    cpl_clr = cm; err_clr = em; pulse();
  endtask
  task automatic wait_idle();
    for (int k = 0; k < 4000 && ch_run != 0; k++) @(negedge clk);
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ch_run == 0 && cpl_vec == 0 && err_vec == 0, "R12", "reset state", 64'(ch_run), 0);
    chk(mv_valid == 0, "R12", "reset mv_valid", 64'(mv_valid), 0);

    // R1, R2, R3, R4, R5: queued job on channel 0
    prog(0, 32'h0000_1000, 32'h0000_8000, 'h1234);
    enable(0);
    chk(ch_run[0] == 1, "R1", "run after idle enable", 64'(ch_run[0]), 1);
    prog(0, 32'h0002_0000, 32'h0003_0000, 'h100);
    enable(0);
    chk(ch_pend[0] == 1, "R2", "pend after busy enable", 64'(ch_pend[0]), 1);
    wait_idle();
    repeat (2) @(negedge clk);
    chk(bytes_ch0 == 'h1334, "R3", "bytes moved ch0", 64'(bytes_ch0), 'h1334);
    chk(bursts_ch0 == 4, "R4", "bursts ch0", 64'(bursts_ch0), 4);
    chk(ch_pend[0] == 0 && ch_run[0] == 0, "R5", "ch0 ended", 64'(ch_run), 0);
    chk(cpl_vec[0] == 1, "R6", "cpl bit ch0", 64'(cpl_vec), 1);

    // R10: write-one-to-clear
    clr(4'hF, 4'hF);
    chk(cpl_vec == 0, "R10", "cpl cleared", 64'(cpl_vec), 0);

    // R7: stop mid-transfer, with a pending set
    prog(1, 32'h100, 32'h200, 'h1FFF);
    enable(1);
    enable(1);
    repeat (5) @(negedge clk);
    stop(1);
    chk(ch_run[1] == 0 && ch_pend[1] == 0, "R7", "stop clears", 64'({ch_pend, ch_run}), 0);
    repeat (8) @(negedge clk);
    chk(cpl_vec[1] == 0, "R7", "no completion after stop", 64'(cpl_vec), 0);

    // R8, R6: suppression
    enable(1);
    sup(1, 1);
    chk(sup_nack == 1, "R8", "refused while running", 64'(sup_nack), 1);
    stop(1);
    sup(1, 2);
    chk(sup_nack == 1, "R8", "refused value 2", 64'(sup_nack), 1);
    sup(1, 1);
    chk(sup_nack == 0, "R8", "accepted", 64'(sup_nack), 0);
    prog(1, 32'h400, 32'h800, 'h10);
    enable(1);
    wait_idle();
    repeat (2) @(negedge clk);
    chk(cpl_vec[1] == 0, "R6", "suppressed completion", 64'(cpl_vec), 0);
    enable(1);
    wait_idle();
    repeat (2) @(negedge clk);
    chk(cpl_vec[1] == 1, "R6", "next completion reported", 64'(cpl_vec), 2);

    // R9: fault on second visit
    fault(2, 2);
    prog(2, 32'h5000, 32'h6000, 'h1000);
    enable(2);
    wait_idle();
    repeat (2) @(negedge clk);
    chk(err_vec[2] == 1, "R9", "error bit ch2", 64'(err_vec), 4);
    chk(cpl_vec[2] == 0, "R9", "no completion ch2", 64'(cpl_vec), 2);
    clr(4'hF, 4'hF);

    // R11, R12: four channels under irregular back-pressure
    for (int i = 0; i < 4; i++) prog(i, 32'(i) << 16, 32'h8000_0000 | (32'(i) << 16), 'h0A00 + i * 'h300);
    for (int i = 0; i < 4; i++) enable(i);
    for (int k = 0; k < 600 && ch_run != 0; k++) begin
      mv_ready = (k % 3 != 0) && (k % 17 > 4);
      @(negedge clk);
    end
    mv_ready = 1;
    wait_idle();
    repeat (2) @(negedge clk);
    chk(cpl_vec == 4'hF, "R11", "all channels completed", 64'(cpl_vec), 'hF);
    // held burst under a long stall
    prog(3, 32'hA000, 32'hB000, 'h1800);
    enable(3);
    mv_ready = 0;
    repeat (6) @(negedge clk);
    chk(mv_valid == 1 && mv_len == 13'h800, "R12", "held burst", 64'(mv_len), 'h800);
    mv_ready = 1;
    wait_idle();
    repeat (2) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule